// File: doc/BRIEF.md
# Calibrated ADC Code-to-Millivolt Converter

This block turns a 12-bit raw converter code into a voltage in millivolts. It first interpolates along a straight line through two calibration points. One line covers a large range (3600 to 4200 mV) and one covers a small range (100 to 1000 mV). Each point's code is rebuilt from a trim byte, and the result is clamped so that it never goes below zero. For all channels except the two direct channels, the small-range voltage is then rescaled by the channel's external divider ratio, rounded to the nearest integer.

A request carries a code, a channel number and a scale select, and enters through a valid/ready handshake. The result leaves through a second valid/ready handshake, together with an error flag. Both divisions share one multicycle restoring divider, so the block accepts one request at a time. The trim bytes are loaded with a single strobe. The per-channel, per-scale ratio words are written through a small write port.

Top module: `adc_volt_conv`

## Requirements
- R1: On a `calLoad` strobe, each point code is computed as (trim byte + nominal code − 128) × 4. For each range, bits 7:0 of the trim word set the first point (4200 mV or 1000 mV) and bits 15:8 set the second point (3600 mV or 100 mV).
- R2: After reset, the point codes equal the nominal codes × 4, which matches a trim byte of 128. A request accepted in the same cycle as a `calLoad` strobe uses the point codes held before that load.
- R3: The interpolated voltage is (V0 − V1) × (code − C1) / (C0 − C1) + V1, computed in signed arithmetic. The quotient is truncated toward zero.
- R4: If the interpolated voltage is negative, the output is 0.
- R5: Channel 5 returns the large-range voltage and channel 1 returns the small-range voltage, each without any ratio applied, whatever the ratio table holds for them.
- R6: Every other channel returns (V × den + floor(num / 2)) / num, where V is the small-range voltage. Here num is bits 31:16 and den is bits 15:0 of the ratio word for that channel and scale. Results wider than 32 bits saturate to all ones.
- R7: After reset, every ratio entry holds num = 1 and den = 1. A write on `ratioWe` replaces the entry addressed by (`ratioChan`, `ratioScale`), and a scale other than the one written keeps its old entry.
- R8: If a division is by zero (C0 = C1 on the selected range, or num = 0 on a rescaled channel), the output is 0 and `outErr` is 1. Otherwise `outErr` is 0.
- R9: `inReady` is high only while no request is held. It drops after an accepted request. `outValid`, `outMv` and `outErr` stay unchanged until `outReady` is seen high.
- R10: During reset and right after it, `inReady` is 1 and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can accept a request |
| inCode | input | 12 | Raw converter code |
| inChan | input | 5 | Channel number |
| inScale | input | 2 | Scale select used for the ratio lookup |
| calLoad | input | 1 | Load strobe for the trim bytes |
| calBigBytes | input | 16 | Trim bytes for the large range (7:0 first point, 15:8 second point) |
| calSmallBytes | input | 16 | Trim bytes for the small range (7:0 first point, 15:8 second point) |
| ratioWe | input | 1 | Ratio table write enable |
| ratioChan | input | 5 | Channel addressed by the ratio write |
| ratioScale | input | 2 | Scale addressed by the ratio write |
| ratioWord | input | 32 | Ratio word: numerator in 31:16, denominator in 15:0 |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outMv | output | 32 | Voltage in millivolts |
| outErr | output | 1 | Division by zero occurred |

## Verification
The bench uses the default parameters: 12-bit codes, 32 channels by 4 scales, channels 5 and 1 as the direct channels, and nominal point codes 856/733 for the large range and 833/80 for the small range. With these values, a negative quotient that only truncation toward zero gets right is reachable, and so is a pair of trim bytes that makes the large-range point codes equal and forces a zero divisor. A small-range trim brings the line below zero near code 0, which exercises the clamp. The ratio entries chosen exercise rounding both up and down, an exact half, and the cases where a ratio is ignored or is zero.

// File: rtl/adcv_pkg.sv
package adcv_pkg;

  // One-cycle strobes from the sequencer to the datapath.
  typedef struct packed {
    logic capture;
    logic startDiv1;
    logic latchVolt;
    logic startDiv2;
    logic latchRescale;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DIV1, S_RUN1, S_DIV2, S_RUN2, S_DONE
  } ctlState_t;

  // Voltage points of the two lines, in millivolts.
  localparam int BIG_V0_MV   = 4200;
  localparam int BIG_V1_MV   = 3600;
  localparam int SMALL_V0_MV = 1000;
  localparam int SMALL_V1_MV = 100;

  localparam logic [31:0] RATIO_UNITY = 32'h0001_0001;

endpackage

// File: rtl/adcv_divider.sv
module adcv_divider #(
  parameter int W = 49
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    remR, quoR, divR;
  logic [CNTW-1:0] cntR;
  logic [W:0]      shifted, trial;

  assign shifted  = {remR, quoR[W-1]};
  assign trial    = shifted - {1'b0, divR};
  assign quotient = quoR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      divR <= '0;
      cntR <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quoR <= dividend;
        remR <= '0;
        divR <= divisor;
        cntR <= CNTW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (!trial[W]) begin
          remR <= trial[W-1:0];
          quoR <= {quoR[W-2:0], 1'b1};
        end else begin
          remR <= shifted[W-1:0];
          quoR <= {quoR[W-2:0], 1'b0};
        end
        cntR <= cntR - 1'b1;
        if (cntR == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: the sequencer never restarts the shared divider mid-run
  a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);
  // R3: a completion pulse only follows a running division
  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

endmodule

// File: rtl/adcv_ctrl.sv
module adcv_ctrl
  import adcv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        isDirect,
  input  logic        divDone,
  output logic        inReady,
  output logic        outValid,
  output ctlStrobes_t strb
);
  ctlState_t stateR, stateNext;

  always_comb begin
    stateNext = stateR;
    strb      = '0;
    unique case (stateR)
      S_IDLE: if (inValid) begin
        strb.capture = 1'b1;
        stateNext    = S_DIV1;
      end
      S_DIV1: begin
        strb.startDiv1 = 1'b1;
        stateNext      = S_RUN1;
      end
      S_RUN1: if (divDone) begin
        strb.latchVolt = 1'b1;
        stateNext      = isDirect ? S_DONE : S_DIV2;
      end
      S_DIV2: begin
        strb.startDiv2 = 1'b1;
        stateNext      = S_RUN2;
      end
      S_RUN2: if (divDone) begin
        strb.latchRescale = 1'b1;
        stateNext         = S_DONE;
      end
      S_DONE: if (outReady) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateR <= S_IDLE;
    else       stateR <= stateNext;
  end

  assign inReady  = (stateR == S_IDLE);
  assign outValid = (stateR == S_DONE);

  // R9: never ready for input while a result is waiting
  a_r9_ready_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));
  // R9: an accepted request closes the input side
  a_r9_accept_drops: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);

endmodule

// File: rtl/adcv_datapath.sv
module adcv_datapath
  import adcv_pkg::*;
#(
  parameter int CODEW        = 12,
  parameter int CHW          = 5,
  parameter int SCW          = 2,
  parameter int BIG_CHAN     = 5,
  parameter int SMALL_CHAN   = 1,
  parameter int BIG_A0_NOM   = 856,
  parameter int BIG_A1_NOM   = 733,
  parameter int SMALL_A0_NOM = 833,
  parameter int SMALL_A1_NOM = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [CODEW-1:0] inCode,
  input  logic [CHW-1:0]   inChan,
  input  logic [SCW-1:0]   inScale,
  input  logic             calLoad,
  input  logic [15:0]      calBigBytes,
  input  logic [15:0]      calSmallBytes,
  input  logic             ratioWe,
  input  logic [CHW-1:0]   ratioChan,
  input  logic [SCW-1:0]   ratioScale,
  input  logic [31:0]      ratioWord,
  output logic             isDirect,
  output logic             divDone,
  output logic [31:0]      outMv,
  output logic             outErr
);
  localparam int EPW   = CODEW + 6;
  localparam int VOLTW = 32;
  localparam int DIVW  = VOLTW + 16 + 1;
  localparam int IDXW  = CHW + SCW;
  localparam int NENT  = 1 << IDXW;

  function automatic logic signed [EPW-1:0] calPoint(input logic [7:0] trim, input int nom);
    return EPW'((int'(trim) + nom - 128) * 4);
  endfunction

  // Calibrated point codes
  logic signed [EPW-1:0] bigA0, bigA1, smallA0, smallA1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bigA0   <= calPoint(8'd128, BIG_A0_NOM);
      bigA1   <= calPoint(8'd128, BIG_A1_NOM);
      smallA0 <= calPoint(8'd128, SMALL_A0_NOM);
      smallA1 <= calPoint(8'd128, SMALL_A1_NOM);
    end else if (calLoad) begin
      bigA0   <= calPoint(calBigBytes[7:0],    BIG_A0_NOM);
      bigA1   <= calPoint(calBigBytes[15:8],   BIG_A1_NOM);
      smallA0 <= calPoint(calSmallBytes[7:0],  SMALL_A0_NOM);
      smallA1 <= calPoint(calSmallBytes[15:8], SMALL_A1_NOM);
    end
  end

  // Ratio table, one register per (channel, scale)
  logic [31:0]     ratioTab [NENT];
  logic [IDXW-1:0] wrIdx;
  assign wrIdx = {ratioChan, ratioScale};

  for (genvar e = 0; e < NENT; e++) begin : g_ratio
    logic [31:0] entR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               entR <= RATIO_UNITY;
      else if (ratioWe && wrIdx == IDXW'(e))   entR <= ratioWord;
    end
    assign ratioTab[e] = entR;
  end

  // Capture: pick the line and form the signed interpolation terms
  logic useBig;
  int   selA0, selA1, selV0, selV1, capProd, capDiv;

  always_comb begin
    useBig  = (inChan == CHW'(BIG_CHAN));
    selA0   = useBig ? int'(bigA0) : int'(smallA0);
    selA1   = useBig ? int'(bigA1) : int'(smallA1);
    selV0   = useBig ? BIG_V0_MV : SMALL_V0_MV;
    selV1   = useBig ? BIG_V1_MV : SMALL_V1_MV;
    capProd = (selV0 - selV1) * (int'({1'b0, inCode}) - selA1);
    capDiv  = selA0 - selA1;
  end

  int          prodR, divR, v1R;
  logic        directR, err1R;
  logic [31:0] ratioR, voltR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodR   <= 0;
      divR    <= 0;
      v1R     <= 0;
      directR <= 1'b0;
      err1R   <= 1'b0;
      ratioR  <= RATIO_UNITY;
    end else if (strb.capture) begin
      prodR   <= capProd;
      divR    <= capDiv;
      v1R     <= selV1;
      directR <= (inChan == CHW'(BIG_CHAN)) || (inChan == CHW'(SMALL_CHAN));
      err1R   <= (capDiv == 0);
      ratioR  <= ratioTab[{inChan, inScale}];
    end
  end
  assign isDirect = directR;

  // Shared divider and its operand selection
  logic [31:0]     prodMag, divMag;
  logic [DIVW-1:0] divDividend, divDivisor, quo;
  logic            divBusy;

  assign prodMag = prodR < 0 ? 32'(-prodR) : 32'(prodR);
  assign divMag  = divR  < 0 ? 32'(-divR)  : 32'(divR);

  always_comb begin
    if (strb.startDiv2) begin
      divDividend = DIVW'(voltR) * DIVW'(ratioR[15:0]) + DIVW'(ratioR[31:17]);
      divDivisor  = DIVW'(ratioR[31:16]);
    end else begin
      divDividend = DIVW'(prodMag);
      divDivisor  = DIVW'(divMag);
    end
  end

  adcv_divider #(.W(DIVW)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (strb.startDiv1 | strb.startDiv2),
    .dividend (divDividend),
    .divisor  (divDivisor),
    .busy     (divBusy),
    .done     (divDone),
    .quotient (quo)
  );

  // Sign restore, offset, clamp
  logic [31:0]        qSat, voltNext;
  logic               quoNeg, err2;
  logic signed [33:0] qSigned, sumV;

  assign qSat   = |quo[DIVW-1:VOLTW] ? '1 : quo[VOLTW-1:0];
  assign quoNeg = prodR[31] ^ divR[31];
  assign err2   = (ratioR[31:16] == 16'd0);

  always_comb begin
    qSigned = quoNeg ? -$signed({2'b00, qSat}) : $signed({2'b00, qSat});
    sumV    = qSigned + 34'(v1R);
    if (err1R || sumV < 0) voltNext = '0;
    else if (sumV[32])     voltNext = '1;
    else                   voltNext = sumV[31:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      voltR  <= '0;
      outMv  <= '0;
      outErr <= 1'b0;
    end else begin
      if (strb.latchVolt) begin
        voltR <= voltNext;
        if (directR) begin
          outMv  <= voltNext;
          outErr <= err1R;
        end
      end
      if (strb.latchRescale) begin
        outMv  <= (err1R || err2) ? '0 : qSat;
        outErr <= err1R || err2;
      end
    end
  end

  // R6: results are only latched once the divider has finished
  a_r6_latch_after_div: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchVolt || strb.latchRescale) |-> (divDone && !divBusy));

endmodule

// File: rtl/adc_volt_conv.sv
module adc_volt_conv
  import adcv_pkg::*;
#(
  parameter int CODEW        = 12,
  parameter int CHW          = 5,
  parameter int SCW          = 2,
  parameter int BIG_CHAN     = 5,
  parameter int SMALL_CHAN   = 1,
  parameter int BIG_A0_NOM   = 856,
  parameter int BIG_A1_NOM   = 733,
  parameter int SMALL_A0_NOM = 833,
  parameter int SMALL_A1_NOM = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [CODEW-1:0] inCode,
  input  logic [CHW-1:0]   inChan,
  input  logic [SCW-1:0]   inScale,
  input  logic             calLoad,
  input  logic [15:0]      calBigBytes,
  input  logic [15:0]      calSmallBytes,
  input  logic             ratioWe,
  input  logic [CHW-1:0]   ratioChan,
  input  logic [SCW-1:0]   ratioScale,
  input  logic [31:0]      ratioWord,
  output logic             outValid,
  input  logic             outReady,
  output logic [31:0]      outMv,
  output logic             outErr
);
  ctlStrobes_t strb;
  logic        isDirect, divDone;

  adcv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .isDirect (isDirect),
    .divDone  (divDone),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  adcv_datapath #(
    .CODEW(CODEW), .CHW(CHW), .SCW(SCW),
    .BIG_CHAN(BIG_CHAN), .SMALL_CHAN(SMALL_CHAN),
    .BIG_A0_NOM(BIG_A0_NOM), .BIG_A1_NOM(BIG_A1_NOM),
    .SMALL_A0_NOM(SMALL_A0_NOM), .SMALL_A1_NOM(SMALL_A1_NOM)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .inCode        (inCode),
    .inChan        (inChan),
    .inScale       (inScale),
    .calLoad       (calLoad),
    .calBigBytes   (calBigBytes),
    .calSmallBytes (calSmallBytes),
    .ratioWe       (ratioWe),
    .ratioChan     (ratioChan),
    .ratioScale    (ratioScale),
    .ratioWord     (ratioWord),
    .isDirect      (isDirect),
    .divDone       (divDone),
    .outMv         (outMv),
    .outErr        (outErr)
  );

  // R9: a pending result holds until it is taken
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outMv) && $stable(outErr));
  // R8: an error result always carries zero
  a_r8_zero_on_err: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> outMv == 32'd0);

endmodule

// File: tb/tb_adc_volt_conv.sv
module tb_adc_volt_conv;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 12;

  // {channel, scale, code, expected mV}, after the ratio writes, nominal points
  localparam logic [50:0] VEC [NVEC] = '{
    {5'd5,  2'd0, 12'd3424, 32'd4200},  // R5 big line, first point
    {5'd5,  2'd0, 12'd3000, 32'd3682},  // R3 truncation
    {5'd1,  2'd0, 12'd320,  32'd100},   // R5 small line, second point
    {5'd1,  2'd0, 12'd1000, 32'd303},   // R3
    {5'd1,  2'd0, 12'd100,  32'd35},    // R3 negative quotient toward zero
    {5'd1,  2'd0, 12'd4095, 32'd1227},  // R3 top code
    {5'd0,  2'd0, 12'd1000, 32'd303},   // R7 default unity ratio
    {5'd7,  2'd2, 12'd1000, 32'd784},   // R6 round up
    {5'd14, 2'd0, 12'd1000, 32'd4010},  // R6 round down
    {5'd3,  2'd1, 12'd1000, 32'd152},   // R6 exact half rounds up
    {5'd7,  2'd0, 12'd1000, 32'd303},   // R7 other scale untouched
    {5'd5,  2'd3, 12'd3424, 32'd4200}   // R5 ratio ignored on direct channel
  };

  logic        clk = 1'b0, rstN = 1'b0;
  logic        inValid = 1'b0, inReady;
  logic [11:0] inCode = '0;
  logic [4:0]  inChan = '0;
  logic [1:0]  inScale = '0;
  logic        calLoad = 1'b0;
  logic [15:0] calBigBytes = '0, calSmallBytes = '0;
  logic        ratioWe = 1'b0;
  logic [4:0]  ratioChan = '0;
  logic [1:0]  ratioScale = '0;
  logic [31:0] ratioWord = '0;
  logic        outValid, outReady = 1'b1;
  logic [31:0] outMv;
  logic        outErr;

  int nChecks = 0, nFail = 0;
  logic [31:0] mv, held;
  logic        er;
  logic [4:0]  vc;
  logic [1:0]  vs;
  logic [11:0] vcode;
  logic [31:0] vexp;
  logic        okHold;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_volt_conv dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCode(inCode), .inChan(inChan), .inScale(inScale),
    .calLoad(calLoad), .calBigBytes(calBigBytes), .calSmallBytes(calSmallBytes),
    .ratioWe(ratioWe), .ratioChan(ratioChan), .ratioScale(ratioScale),
    .ratioWord(ratioWord), .outValid(outValid), .outReady(outReady),
    .outMv(outMv), .outErr(outErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startConv(input logic [4:0] c, input logic [1:0] s, input logic [11:0] code,
                           input logic doCal, input logic [15:0] bigB, input logic [15:0] smallB);
    @(negedge clk);
    inChan = c; inScale = s; inCode = code; inValid = 1'b1;
    if (doCal) begin
      calLoad = 1'b1; calBigBytes = bigB; calSmallBytes = smallB;
    end
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; calLoad = 1'b0;
  endtask

  task automatic waitResult(output logic [31:0] m, output logic e);
    while (!outValid) @(negedge clk);
    m = outMv; e = outErr;
    if (outReady) @(negedge clk);
  endtask

  task automatic convert(input logic [4:0] c, input logic [1:0] s, input logic [11:0] code,
                         output logic [31:0] m, output logic e);
    startConv(c, s, code, 1'b0, 16'h0, 16'h0);
    waitResult(m, e);
  endtask

  task automatic wrRatio(input logic [4:0] c, input logic [1:0] s, input logic [31:0] w);
    @(negedge clk);
    ratioWe = 1'b1; ratioChan = c; ratioScale = s; ratioWord = w;
    @(negedge clk);
    ratioWe = 1'b0;
  endtask

  task automatic loadCal(input logic [15:0] bigB, input logic [15:0] smallB);
    @(negedge clk);
    calLoad = 1'b1; calBigBytes = bigB; calSmallBytes = smallB;
    @(negedge clk);
    calLoad = 1'b0;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 inReady in reset", {31'd0, inReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 outValid after reset", {31'd0, outValid}, 32'd0);

    wrRatio(5'd7,  2'd2, {16'd1000, 16'd2586});
    wrRatio(5'd14, 2'd0, {16'd68,   16'd900});
    wrRatio(5'd3,  2'd1, {16'd2,    16'd1});
    wrRatio(5'd5,  2'd3, {16'd1,    16'd7});
    wrRatio(5'd1,  2'd0, {16'd2,    16'd1});

    for (int i = 0; i < NVEC; i++) begin
      {vc, vs, vcode, vexp} = VEC[i];
      convert(vc, vs, vcode, mv, er);
      check($sformatf("R3/R5/R6/R7 vector %0d mV", i), mv, vexp);
      check($sformatf("R8 vector %0d err", i), {31'd0, er}, 32'd0);
    end

    // R9 stall: result holds, input side stays closed
    outReady = 1'b0;
    startConv(5'd0, 2'd0, 12'd1000, 1'b0, 16'h0, 16'h0);
    check("R9 inReady low while busy", {31'd0, inReady}, 32'd0);
    waitResult(held, er);
    okHold = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!outValid || outMv !== held || inReady) okHold = 1'b0;
    end
    check("R9 result held under stall", {31'd0, okHold}, 32'd1);
    check("R9 held value", held, 32'd303);
    outReady = 1'b1;
    @(negedge clk);
    check("R9 released", {30'd0, outValid, inReady}, 32'd1);

    // R1 trim bytes: big low 0x90 high 0x70, small low 0x80 high 0x85
    loadCal(16'h7090, 16'h8580);
    convert(5'd5, 2'd0, 12'd3488, mv, er);
    check("R1 big first point from low byte", mv, 32'd4200);
    convert(5'd5, 2'd0, 12'd2868, mv, er);
    check("R1 big second point from high byte", mv, 32'd3600);
    convert(5'd1, 2'd0, 12'd340, mv, er);
    check("R1 small second point", mv, 32'd100);
    convert(5'd1, 2'd0, 12'd3332, mv, er);
    check("R1 small first point", mv, 32'd1000);
    convert(5'd1, 2'd0, 12'd0, mv, er);
    check("R4 negative clamps to zero", mv, 32'd0);
    check("R4 clamp is no error", {31'd0, er}, 32'd0);

    // R8 zero numerator on a rescaled channel
    wrRatio(5'd2, 2'd0, {16'd0, 16'd5});
    convert(5'd2, 2'd0, 12'd1000, mv, er);
    check("R8 zero num value", mv, 32'd0);
    check("R8 zero num err", {31'd0, er}, 32'd1);

    // R8 equal big point codes
    loadCal(16'h7B00, 16'h8580);
    convert(5'd5, 2'd0, 12'd1000, mv, er);
    check("R8 equal points value", mv, 32'd0);
    check("R8 equal points err", {31'd0, er}, 32'd1);
    convert(5'd1, 2'd0, 12'd340, mv, er);
    check("R8 small line unaffected", {er, mv[30:0]}, 32'd100);

    // R7 reset restores unity ratios
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    convert(5'd7, 2'd2, 12'd1000, mv, er);
    check("R7 unity after reset", mv, 32'd303);

    // R2 load coinciding with accept uses nominal points
    startConv(5'd5, 2'd0, 12'd3424, 1'b1, 16'h7090, 16'h8080);
    waitResult(mv, er);
    check("R2 nominal points at accept", mv, 32'd4200);
    convert(5'd5, 2'd0, 12'd3424, mv, er);
    check("R2 loaded points next request", mv, 32'd4138);

    finishRun();
  end

endmodule